// File: doc/BRIEF.md
# Eight-Channel DAC Control Core

This block is the digital control core of an eight-channel voltage-output DAC. It takes 32-bit command frames from a three-wire serial link: a serial clock, an active-low frame strobe and a data line. It decodes each frame into a command and keeps two registers per channel. A staging (input) register takes the new code. A DAC register holds the code that the analog section actually converts. Channels 0 to 3 have 12-bit resolution and channels 4 to 7 have 16-bit resolution. All eight codes leave the block right-aligned in 16-bit lanes.

Staged codes move to the DAC registers in several ways: by a load command, by a combined write-and-load command, or by an active-low hardware load pin that updates every selected channel in the same clock. An auto-load mask lets chosen channels skip staging and update on every write. An active-low clear pin forces every DAC register to a selectable clear level (zero, midscale or full scale) and leaves the staging registers untouched. The block also holds a two-bit power-down mode per channel and a reference-enable bit, and passes both to the analog section.

All serial and pin inputs are sampled into the system clock domain through two-flop synchronizers. This includes the load and clear pins.

Top module: `octdac_ctl`

## Requirements
- R1: A frame is shifted in MSB first on falling edges of `ser_clk_i` while `ser_frame_n_i` is low. Each line level must be held for at least two `clk` periods. Of the 32-bit word, bits [27:24] are the command, bits [23:20] the channel address and bits [19:4] the 16-bit data; bits [31:28] and [3:0] are ignored. The command executes after the 32nd bit. Any further bits before `ser_frame_n_i` rises are ignored.
- R2: If `ser_frame_n_i` rises before 32 bits have arrived, the frame is dropped and no state changes.
- R3: Command 0 writes the staging register of the addressed channel and leaves `code_o` unchanged for channels whose auto-load bit is clear. Channels 0 to 3 store data[15:4] in lane bits [11:0] with bits [15:12] zero. Channels 4 to 7 store all 16 data bits. Channel k occupies `code_o[16k+15:16k]`.
- R4: Command 1 copies the staging register to the DAC register of the addressed channel. Address 15 selects all channels, addresses 0 to 7 select one channel, and addresses 8 to 14 select none.
- R5: Command 2 writes the addressed staging register and then loads all eight DAC registers. Command 3 writes both the staging and the DAC register of the addressed channel only.
- R6: While `load_n_i` is low, every channel whose auto-load bit is clear copies staging into DAC in the same clock.
- R7: Command 6 sets the auto-load mask from data[7:0], where bit k belongs to channel k. A channel whose bit is set loads its DAC register on every staging write, and the load pin does not act on it.
- R8: While `clear_n_i` is low, every DAC register holds the clear level chosen by command 5. For data[1:0], 0 selects zero, 1 selects midscale (0x800 or 0x8000), 2 selects full scale (0xFFF or 0xFFFF), and 3 selects zero. Staging registers keep their values.
- R9: Command 4 sets all power-down modes at once. Data bits [2k+1:2k] are the mode of channel k and appear on `pdmode_o[2k+1:2k]`, where 0 is normal operation.
- R10: `refen_o` is 0 after reset and changes only through command 8, which sets it to data[0].
- R11: After reset, and after command 7, all codes, modes, the mask, the clear select and `refen_o` are zero.
- R12: Command codes 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| ser_frame_n_i | input | 1 | Active-low frame strobe |
| ser_data_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Active-low hardware load request |
| clear_n_i | input | 1 | Active-low clear request |
| code_o | output | 128 | DAC-register codes, 16-bit lane per channel |
| pdmode_o | output | 16 | Power-down mode, 2 bits per channel |
| refen_o | output | 1 | Internal reference enable |

## Verification
The assertions assume the serial and pin inputs change slowly compared with `clk`: each level lasts at least two clock periods, and the serial clock is high whenever the frame strobe falls, so no false falling edge is seen. Under that assumption, two frame-valid pulses can never be adjacent, and a DAC register can only move in the cycle after a frame, a load or a clear. The stimulus keeps the serial clock at four clock periods per level. It raises the serial clock before each frame begins and holds the load and clear pins low for six periods.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    parameter int CH_NUM     = 8;
    parameter int NARROW_NUM = 4;
    parameter int NARROW_W   = 12;
    parameter int CODE_W     = 16;
    parameter int CMD_W      = 4;
    parameter int ADDR_W     = 4;
    parameter int PAD_W      = 4;
    parameter int PD_W       = 2;
    parameter int FRAME_BITS = 32;
    parameter int SYNC_STAGES = 2;

    localparam int CNT_W    = $clog2(FRAME_BITS + 1);
    localparam int FIELD_W  = CMD_W + ADDR_W + CODE_W;
    localparam int SH_W     = FIELD_W + PAD_W - 1;
    localparam int PDV_W    = CH_NUM * PD_W;
    localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_IN       = 4'd0,
        CMD_LOAD        = 4'd1,
        CMD_WR_LOAD_ALL = 4'd2,
        CMD_WR_LOAD_ONE = 4'd3,
        CMD_PWR         = 4'd4,
        CMD_CLR_SEL     = 4'd5,
        CMD_MASK        = 4'd6,
        CMD_RESET       = 4'd7,
        CMD_REF         = 4'd8
    } octdac_cmd_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] data;
    } octdac_frame_t;

    // Align a 16-bit data word to the resolution of channel ch.
    function automatic logic [CODE_W-1:0] fit_code(input int ch, input logic [CODE_W-1:0] d);
        if (ch < NARROW_NUM)
            return {{(CODE_W-NARROW_W){1'b0}}, d[CODE_W-1 -: NARROW_W]};
        return d;
    endfunction

    // Clear level of channel ch for select value sel.
    function automatic logic [CODE_W-1:0] clear_code(input int ch, input logic [1:0] sel);
        logic [CODE_W:0] top;
        logic [CODE_W:0] full;
        int w;
        w    = (ch < NARROW_NUM) ? NARROW_W : CODE_W;
        top  = (CODE_W+1)'(1) << w;
        full = top - (CODE_W+1)'(1);
        case (sel)
            2'd1:    return top[CODE_W:1];
            2'd2:    return full[CODE_W-1:0];
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/octdac_frame_rx.sv
module octdac_frame_rx
    import octdac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s_i,
    input  logic          frame_n_s_i,
    input  logic          sdata_s_i,
    output logic          frame_vld_o,
    output octdac_frame_t frame_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   shreg;
        logic              vld;
        octdac_frame_t     frame;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      fall;
    logic [SH_W:0] next_sh;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_prev = sclk_s_i;
        s_d.vld       = 1'b0;
        fall          = s_q.sclk_prev & ~sclk_s_i;
        next_sh       = {s_q.shreg, sdata_s_i};
        if (frame_n_s_i) begin
            s_d.cnt = '0;
        end else if (fall && (s_q.cnt < FULL_CNT)) begin
            s_d.shreg = next_sh[SH_W-1:0];
            s_d.cnt   = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == LAST_CNT) begin
                s_d.vld   = 1'b1;
                s_d.frame = next_sh[SH_W -: FIELD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.sclk_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_vld_o = s_q.vld;
    assign frame_o     = s_q.frame;

    AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT); // R1
    AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |-> (s_q.cnt == FULL_CNT) && ($past(s_q.cnt) == LAST_CNT)); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |=> !s_q.vld); // R1
    AST_STROBE_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n_s_i |=> (s_q.cnt == '0) && !s_q.vld); // R2

endmodule

// File: rtl/octdac_regbank.sv
module octdac_regbank
    import octdac_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_vld_i,
    input  octdac_frame_t                  frame_i,
    input  logic                           load_s_i,
    input  logic                           clear_s_i,
    output logic [CH_NUM-1:0][CODE_W-1:0]  dac_o,
    output logic [PDV_W-1:0]               pd_o,
    output logic                           ref_o
);

    typedef struct packed {
        logic [CH_NUM-1:0][CODE_W-1:0] inp;
        logic [CH_NUM-1:0][CODE_W-1:0] dac;
        logic [CH_NUM-1:0][PD_W-1:0]   pd;
        logic [CH_NUM-1:0]             amask;
        logic [1:0]                    csel;
        logic                          ref_en;
    } bank_t;

    bank_t b_d, b_q;

    logic [CH_NUM-1:0]             hit;
    logic [CH_NUM-1:0][CODE_W-1:0] wdata;
    logic [CH_NUM-1:0][CODE_W-1:0] cval;

    // Per-channel address decode, data alignment and clear level.
    for (genvar g = 0; g < CH_NUM; g++) begin : g_lane
        assign hit[g]   = (frame_i.addr == ADDR_W'(g)) || (frame_i.addr == ADDR_ALL);
        assign wdata[g] = fit_code(g, frame_i.data);
        assign cval[g]  = clear_code(g, b_q.csel);

        AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
            clear_s_i |=> b_q.dac[g] == clear_code(g, $past(b_q.csel))); // R8
    end

    always_comb begin
        b_d = b_q;
        if (frame_vld_i) begin
            case (frame_i.cmd)
                CMD_WR_IN: begin
                    for (int k = 0; k < CH_NUM; k++) begin
                        if (hit[k]) begin
                            b_d.inp[k] = wdata[k];
                            if (b_q.amask[k]) b_d.dac[k] = wdata[k];
                        end
                    end
                end
                CMD_LOAD: begin
                    for (int k = 0; k < CH_NUM; k++) begin
                        if (hit[k]) b_d.dac[k] = b_q.inp[k];
                    end
                end
                CMD_WR_LOAD_ALL: begin
                    for (int k = 0; k < CH_NUM; k++) begin
                        if (hit[k]) b_d.inp[k] = wdata[k];
                        b_d.dac[k] = b_d.inp[k];
                    end
                end
                CMD_WR_LOAD_ONE: begin
                    for (int k = 0; k < CH_NUM; k++) begin
                        if (hit[k]) begin
                            b_d.inp[k] = wdata[k];
                            b_d.dac[k] = wdata[k];
                        end
                    end
                end
                CMD_PWR:     b_d.pd     = frame_i.data;
                CMD_CLR_SEL: b_d.csel   = frame_i.data[1:0];
                CMD_MASK:    b_d.amask  = frame_i.data[CH_NUM-1:0];
                CMD_RESET:   b_d        = '0;
                CMD_REF:     b_d.ref_en = frame_i.data[0];
                default: ;
            endcase
        end
        if (load_s_i) begin
            for (int k = 0; k < CH_NUM; k++) begin
                if (!b_d.amask[k]) b_d.dac[k] = b_d.inp[k];
            end
        end
        if (clear_s_i) begin
            for (int k = 0; k < CH_NUM; k++) begin
                b_d.dac[k] = cval[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign dac_o = b_q.dac;
    assign pd_o  = b_q.pd;
    assign ref_o = b_q.ref_en;

    AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_vld_i) && !$past(load_s_i) && !$past(clear_s_i)) |-> $stable(b_q.dac)); // R3
    AST_REF_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_q.ref_en) |-> $past(frame_vld_i && (frame_i.cmd == CMD_REF))); // R10
    AST_PD_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.pd != $past(b_q.pd)) |->
            $past(frame_vld_i && ((frame_i.cmd == CMD_PWR) || (frame_i.cmd == CMD_RESET)))); // R9
    AST_CLEAR_KEEPS_STAGING: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_s_i && !frame_vld_i) |=> $stable(b_q.inp)); // R8

endmodule

// File: rtl/octdac_ctl.sv
module octdac_ctl
    import octdac_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk_i,
    input  logic                       ser_frame_n_i,
    input  logic                       ser_data_i,
    input  logic                       load_n_i,
    input  logic                       clear_n_i,
    output logic [CH_NUM*CODE_W-1:0]   code_o,
    output logic [PDV_W-1:0]           pdmode_o,
    output logic                       refen_o
);

    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] synced;
    logic             frame_vld;
    octdac_frame_t    frame;
    logic [CH_NUM-1:0][CODE_W-1:0] dac;

    assign raw_in = {ser_clk_i, ser_frame_n_i, ser_data_i, load_n_i, clear_n_i};

    octdac_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b11011)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    octdac_frame_rx rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s_i    (synced[4]),
        .frame_n_s_i (synced[3]),
        .sdata_s_i   (synced[2]),
        .frame_vld_o (frame_vld),
        .frame_o     (frame)
    );

    octdac_regbank bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_vld_i (frame_vld),
        .frame_i     (frame),
        .load_s_i    (~synced[1]),
        .clear_s_i   (~synced[0]),
        .dac_o       (dac),
        .pd_o        (pdmode_o),
        .ref_o       (refen_o)
    );

    assign code_o = dac;

endmodule

// File: tb/octdac_ctl_tb_top.sv
module octdac_ctl_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b1;
    logic         ser_frame_n = 1'b1;
    logic         ser_data = 1'b0;
    logic         load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [127:0] code;
    logic [15:0]  pdmode;
    logic         refen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_in  [8];
    logic [15:0] m_dac [8];
    logic [7:0]  m_mask;
    logic [1:0]  m_csel;
    logic [15:0] m_pd;
    logic        m_ref;

    always #2 clk = ~clk;

    octdac_ctl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_clk_i     (ser_clk),
        .ser_frame_n_i (ser_frame_n),
        .ser_data_i    (ser_data),
        .load_n_i      (load_n),
        .clear_n_i     (clear_n),
        .code_o        (code),
        .pdmode_o      (pdmode),
        .refen_o       (refen)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fit(input int k, input logic [15:0] d);
        return (k < 4) ? (d >> 4) : d;
    endfunction

    function automatic logic [15:0] clr_level(input int k, input logic [1:0] sel);
        if (sel == 2'd1) return (k < 4) ? 16'h0800 : 16'h8000;
        if (sel == 2'd2) return (k < 4) ? 16'h0FFF : 16'hFFFF;
        return 16'h0000;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_in[k]  = '0;
            m_dac[k] = '0;
        end
        m_mask = '0; m_csel = '0; m_pd = '0; m_ref = 1'b0;
    endtask

    task automatic model_cmd(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
        for (int k = 0; k < 8; k++) begin
            bit h;
            h = (addr == 4'(k)) || (addr == 4'hF);
            case (cmd)
                4'd0: if (h) begin m_in[k] = fit(k, data); if (m_mask[k]) m_dac[k] = fit(k, data); end
                4'd1: if (h) m_dac[k] = m_in[k];
                4'd2: begin if (h) m_in[k] = fit(k, data); end
                4'd3: if (h) begin m_in[k] = fit(k, data); m_dac[k] = fit(k, data); end
                default: ;
            endcase
        end
        case (cmd)
            4'd2: for (int k = 0; k < 8; k++) m_dac[k] = m_in[k];
            4'd4: m_pd = data;
            4'd5: m_csel = data[1:0];
            4'd6: m_mask = data[7:0];
            4'd7: model_reset();
            4'd8: m_ref = data[0];
            default: ;
        endcase
    endtask

    task automatic check_state(input string req);
        for (int k = 0; k < 8; k++) begin
            chk(req, $sformatf("code lane %0d", k), {16'h0, code[16*k +: 16]}, {16'h0, m_dac[k]});
        end
        chk(req, "pdmode", {16'h0, pdmode}, {16'h0, m_pd});
        chk(req, "refen", {31'h0, refen}, {31'h0, m_ref});
    endtask

    // Sends the first nbits of a frame, then extra bits of ones.
    task automatic send_bits(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data,
                             input int nbits, input int extra);
        logic [31:0] word;
        word = {4'hA, cmd, addr, data, 4'h5};
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_frame_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits + extra; i++) begin
            ser_clk  = 1'b1;
            ser_data = (i < nbits) ? word[31 - i] : 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        ser_frame_n = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
        send_bits(cmd, addr, data, 32, 0);
        model_cmd(cmd, addr, data);
    endtask

    task automatic t_reset();
        model_reset();
        check_state("R11");
    endtask

    task automatic t_stage_then_load();
        do_cmd(4'd0, 4'd5, 16'hABCD);
        check_state("R3");
        do_cmd(4'd1, 4'd5, 16'h0000);
        chk("R4", "lane 5 after load", {16'h0, code[80 +: 16]}, 32'hABCD);
        do_cmd(4'd0, 4'd2, 16'h1234);
        do_cmd(4'd1, 4'd2, 16'h0000);
        chk("R3", "narrow lane 2", {16'h0, code[32 +: 16]}, 32'h0123);
        check_state("R3");
    endtask

    task automatic t_addressing();
        do_cmd(4'd0, 4'hF, 16'h8421);
        do_cmd(4'd1, 4'hF, 16'h0000);
        check_state("R4");
        do_cmd(4'd0, 4'd9, 16'h1111);
        do_cmd(4'd1, 4'hF, 16'h0000);
        check_state("R4");
    endtask

    task automatic t_write_load();
        do_cmd(4'd3, 4'd7, 16'h5555);
        check_state("R5");
        do_cmd(4'd0, 4'd6, 16'h7777);
        do_cmd(4'd2, 4'd0, 16'hFFF0);
        chk("R5", "lane 6 loaded by all", {16'h0, code[96 +: 16]}, 32'h7777);
        check_state("R5");
    endtask

    task automatic t_framing();
        send_bits(4'd3, 4'd3, 16'hAAAA, 20, 0);
        check_state("R2");
        send_bits(4'd3, 4'd3, 16'hAAAA, 31, 0);
        check_state("R2");
        send_bits(4'd3, 4'd3, 16'h9990, 32, 4);
        model_cmd(4'd3, 4'd3, 16'h9990);
        chk("R1", "lane 3 with trailing bits", {16'h0, code[48 +: 16]}, 32'h0999);
        check_state("R1");
    endtask

    task automatic t_mask_and_pin();
        do_cmd(4'd6, 4'hF, 16'h0010);
        do_cmd(4'd0, 4'd4, 16'h4444);
        chk("R7", "masked lane 4", {16'h0, code[64 +: 16]}, 32'h4444);
        do_cmd(4'd0, 4'd1, 16'h3330);
        check_state("R6");
        load_n = 1'b0;
        repeat (6) @(negedge clk);
        load_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int k = 0; k < 8; k++) if (!m_mask[k]) m_dac[k] = m_in[k];
        chk("R6", "lane 1 after pin", {16'h0, code[16 +: 16]}, 32'h0333);
        check_state("R6");
        do_cmd(4'd6, 4'hF, 16'h0000);
        check_state("R7");
    endtask

    task automatic pulse_clear();
        clear_n = 1'b0;
        repeat (6) @(negedge clk);
        clear_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int k = 0; k < 8; k++) m_dac[k] = clr_level(k, m_csel);
    endtask

    task automatic t_clear();
        for (int sel = 1; sel < 4; sel++) begin
            do_cmd(4'd5, 4'd0, 16'(sel));
            pulse_clear();
            check_state("R8");
            do_cmd(4'd1, 4'hF, 16'h0000);
            check_state("R8");
        end
    endtask

    task automatic t_power();
        do_cmd(4'd4, 4'hF, 16'h1BE4);
        chk("R9", "pdmode", {16'h0, pdmode}, 32'h1BE4);
        check_state("R9");
    endtask

    task automatic t_reference();
        do_cmd(4'd8, 4'd0, 16'h0001);
        chk("R10", "refen set", {31'h0, refen}, 32'h1);
        do_cmd(4'd8, 4'd0, 16'h0000);
        check_state("R10");
    endtask

    task automatic t_unused();
        do_cmd(4'd0, 4'hF, 16'h2460);
        do_cmd(4'd9, 4'hF, 16'hFFFF);
        do_cmd(4'd15, 4'd3, 16'hFFFF);
        do_cmd(4'd12, 4'hF, 16'h0000);
        check_state("R12");
    endtask

    task automatic t_soft_reset();
        do_cmd(4'd8, 4'd0, 16'h0001);
        do_cmd(4'd6, 4'hF, 16'h00FF);
        do_cmd(4'd7, 4'd0, 16'h0000);
        check_state("R11");
        do_cmd(4'd1, 4'hF, 16'h0000);
        check_state("R11");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_stage_then_load();
        t_addressing();
        t_write_load();
        t_framing();
        t_mask_and_pin();
        t_clear();
        t_power();
        t_reference();
        t_unused();
        t_soft_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule